// File: doc/BRIEF.md
# UART Interrupt Status and Masking Unit

This unit sits beside a UART's serial engine. It turns the engine's event pulses and FIFO fill levels into latched interrupt flags. A software-visible enable register gates those flags, and the gated flags are ORed into a single interrupt line. The serial engine, FIFOs, baud logic and DMA engines are not part of this unit. They appear only as the pulse and level inputs listed below.

Software reaches the unit through a small register window of four words. The words are the enable mask (read/write), the latched flags (read), the gated flags (read) and a write-one-to-clear port. The transmit and receive flags are driven by FIFO fill level, and they drop by themselves when the level moves back across its threshold. The transmit flag can instead follow end-of-transmission. The receive-timeout flag is never recorded or shown while its enable bit is off.

Top module: `uart_irq_ctl`

## Requirements
- R1: Sources map to these flag bit positions: 0 ring indicator, 1 clear-to-send, 2 carrier detect, 3 data-set-ready, 4 receive level, 5 transmit, 6 receive timeout, 7 framing error, 8 parity error, 9 break, 10 overrun, 11 end of transmission, 12 nine-bit address match, 16 receive DMA done, 17 transmit DMA done. An event pulse sets its flag at the clock edge on which it is sampled. Bits 13-15 and 18-31 always read zero.
- R2: The gated word equals latched flags AND enable mask. `irq` is the OR of the gated word, and it follows a mask write on the edge that stores the mask.
- R3: Writing the clear word clears each latched flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R4: When an event and a clear of the same flag occur in one cycle, the flag ends up set.
- R5: With `eot_mode`=0, the transmit flag sets when `tx_level` goes from above the threshold to at or below it. The threshold is `tx_trig` when `fifo_en`=1 and 0 when `fifo_en`=0.
- R6: With `eot_mode`=0, the transmit flag clears itself. When `fifo_en`=1 this happens when `tx_level` rises from at or below `tx_trig` to above it. When `fifo_en`=0 it happens on a `tx_wr` strobe.
- R7: The receive flag sets when `rx_level` goes from below the threshold to at or above it. The threshold is `rx_trig` when `fifo_en`=1 and 1 when `fifo_en`=0. The flag clears itself when the level falls back below the threshold (`fifo_en`=1) or on an `rx_rd` strobe (`fifo_en`=0).
- R8: With `eot_mode`=1, the transmit flag sets on `tx_done_ev` and ignores level crossings. `tx_done_ev` always sets bit 11.
- R9: A receive-timeout pulse is not recorded while mask bit 6 is 0. A timeout pulse that arrived while masked never appears later.
- R10: Each modem bit of `modem_in` sets its flag on any change, rising or falling, relative to its value one cycle earlier.
- R11: Reset clears all latched flags and all mask bits, so every readable word and `irq` read 0.
- R12: `reg_addr` selects 0 mask, 1 latched flags, 2 gated flags and 3 clear. The clear word reads 0. Mask bits outside the implemented set read 0, so writing all ones reads back 0x0003_1FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| fifo_en | input | 1 | FIFO mode enabled |
| eot_mode | input | 1 | Transmit flag follows end of transmission |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_trig | input | LVL_W | Transmit threshold |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive threshold |
| tx_wr | input | 1 | Byte written to transmitter |
| rx_rd | input | 1 | Byte read from receiver |
| modem_in | input | 4 | Synchronized modem lines: 0 RI, 1 CTS, 2 DCD, 3 DSR |
| rx_tmo_ev | input | 1 | Receive timeout pulse |
| frame_err_ev | input | 1 | Framing error pulse |
| parity_err_ev | input | 1 | Parity error pulse |
| break_err_ev | input | 1 | Break pulse |
| overrun_ev | input | 1 | Overrun pulse |
| tx_done_ev | input | 1 | Last data bit shifted out |
| addr_match_ev | input | 1 | Nine-bit address match |
| rx_dma_done | input | 1 | Receive DMA complete |
| tx_dma_done | input | 1 | Transmit DMA complete |
| irq | output | 1 | Combined interrupt |

## Verification
Every pulse source is swept with its mask bit both off and on. Each step checks the latched word, the gated word and `irq`, which separates bit placement from gating and shows the timeout exception. Each transmit threshold from 0 to 14 and each receive threshold from 1 to 15 is driven with levels one step away in both directions. This tells set-on-crossing apart from set-on-level, and self-clear apart from a stuck flag. Both modem edges are toggled on every line, with a stable cycle in between so that level-sensitive detection would show up. The FIFO-off strobes, end-of-transmission mode and an event colliding with a clear are each tried on their own.

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             fifo_en,
  input  logic             eot_mode,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_trig,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             tx_wr,
  input  logic             rx_rd,
  input  logic [3:0]       modem_in,
  input  logic             rx_tmo_ev,
  input  logic             frame_err_ev,
  input  logic             parity_err_ev,
  input  logic             break_err_ev,
  input  logic             overrun_ev,
  input  logic             tx_done_ev,
  input  logic             addr_match_ev,
  input  logic             rx_dma_done,
  input  logic             tx_dma_done,
  output logic             irq
);
  localparam logic [31:0] IMPL   = 32'h0003_1FFF;
  localparam logic [1:0]  A_MASK = 2'd0;
  localparam logic [1:0]  A_RAW  = 2'd1;
  localparam logic [1:0]  A_GATE = 2'd2;

  logic [31:0]      raw_q, mask_q, set_v, clr_v, raw_vis, gated;
  logic [3:0]       modem_q;
  logic [LVL_W-1:0] tx_lvl_q, rx_lvl_q, tx_th, rx_th;
  logic             primed_q;
  logic             tx_hi_now, tx_hi_old, rx_ok_now, rx_ok_old;
  logic             tx_set, tx_drop, rx_set, rx_drop;

  assign tx_th = fifo_en ? tx_trig : '0;
  assign rx_th = fifo_en ? rx_trig : LVL_W'(1);

  assign tx_hi_now = tx_level > tx_th;
  assign tx_hi_old = tx_lvl_q > tx_th;
  assign rx_ok_now = rx_level >= rx_th;
  assign rx_ok_old = rx_lvl_q >= rx_th;

  assign tx_set  = eot_mode ? tx_done_ev : (primed_q & tx_hi_old & ~tx_hi_now);
  assign tx_drop = ~eot_mode & (fifo_en ? (primed_q & ~tx_hi_old & tx_hi_now) : tx_wr);
  assign rx_set  = primed_q & ~rx_ok_old & rx_ok_now;
  assign rx_drop = fifo_en ? (primed_q & rx_ok_old & ~rx_ok_now) : rx_rd;

  always_comb begin
    set_v      = '0;
    set_v[3:0] = primed_q ? (modem_in ^ modem_q) : 4'b0;
    set_v[4]   = rx_set;
    set_v[5]   = tx_set;
    set_v[6]   = rx_tmo_ev & mask_q[6];
    set_v[7]   = frame_err_ev;
    set_v[8]   = parity_err_ev;
    set_v[9]   = break_err_ev;
    set_v[10]  = overrun_ev;
    set_v[11]  = tx_done_ev;
    set_v[12]  = addr_match_ev;
    set_v[16]  = rx_dma_done;
    set_v[17]  = tx_dma_done;
  end

  always_comb begin
    clr_v    = (reg_wr && reg_addr == 2'd3) ? reg_wdata : '0;
    clr_v[4] = clr_v[4] | rx_drop;
    clr_v[5] = clr_v[5] | tx_drop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q    <= '0;
      mask_q   <= '0;
      modem_q  <= '0;
      tx_lvl_q <= '0;
      rx_lvl_q <= '0;
      primed_q <= 1'b0;
    end else begin
      raw_q    <= ((raw_q & ~clr_v) | set_v) & IMPL;
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata & IMPL;
      modem_q  <= modem_in;
      tx_lvl_q <= tx_level;
      rx_lvl_q <= rx_level;
      primed_q <= 1'b1;
    end
  end

  assign raw_vis = {raw_q[31:7], raw_q[6] & mask_q[6], raw_q[5:0]};
  assign gated   = raw_vis & mask_q;
  assign irq     = |gated;

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = mask_q;
      A_RAW:   reg_rdata = raw_vis;
      A_GATE:  reg_rdata = gated;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_ctl_chk.sv
module uart_irq_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        eot_mode,
  input logic        tx_done_ev,
  input logic        frame_err_ev,
  input logic        break_err_ev,
  input logic [3:0]  modem_in,
  input logic [31:0] raw_q,
  input logic [31:0] mask_q,
  input logic [3:0]  modem_q,
  input logic        primed_q
);
  // R2
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> mask_q == ($past(reg_wdata) & 32'h0003_1FFF));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3 && reg_wdata[9] && !break_err_ev) |=> !raw_q[9]);

  // R4
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3 && reg_wdata[7] && frame_err_ev) |=> raw_q[7]);

  // R8
  eot_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_mode && tx_done_ev) |=> (raw_q[5] && raw_q[11]));

  // R9
  tmo_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q[6] && !raw_q[6]) |=> !raw_q[6]);

  // R10
  modem_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && modem_in[1] != modem_q[1]) |=> raw_q[1]);
endmodule

bind uart_irq_ctl uart_irq_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .eot_mode(eot_mode), .tx_done_ev(tx_done_ev),
  .frame_err_ev(frame_err_ev), .break_err_ev(break_err_ev),
  .modem_in(modem_in), .raw_q(raw_q), .mask_q(mask_q),
  .modem_q(modem_q), .primed_q(primed_q)
);

// File: tb/test_uart_irq_ctl.sv
module test_uart_irq_ctl;
  localparam int CLK_P = 10;
  localparam int LW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          fifo_en = 1'b1, eot_mode = 1'b0;
  logic [LW-1:0] tx_level = '0, tx_trig = '0, rx_level = '0, rx_trig = '0;
  logic [3:0]    modem_in = '0;
  logic [31:0]   pv = '0;
  logic          irq;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  uart_irq_ctl #(.LVL_W(LW)) i_uart_irq_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_en(fifo_en),
    .eot_mode(eot_mode), .tx_level(tx_level), .tx_trig(tx_trig),
    .rx_level(rx_level), .rx_trig(rx_trig), .tx_wr(pv[20]), .rx_rd(pv[21]),
    .modem_in(modem_in), .rx_tmo_ev(pv[6]), .frame_err_ev(pv[7]),
    .parity_err_ev(pv[8]), .break_err_ev(pv[9]), .overrun_ev(pv[10]),
    .tx_done_ev(pv[11]), .addr_match_ev(pv[12]), .rx_dma_done(pv[16]),
    .tx_dma_done(pv[17]), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    pv = v;
    @(negedge clk);
    pv = '0;
  endtask

  task automatic set_tx(input logic [LW-1:0] v);
    @(negedge clk);
    tx_level = v;
    @(negedge clk);
  endtask

  task automatic set_rx(input logic [LW-1:0] v);
    @(negedge clk);
    rx_level = v;
    @(negedge clk);
  endtask

  task automatic raw_bit(input string req, input int b, input logic e);
    logic [31:0] d;
    rd(2'd1, d);
    chk(req, {31'b0, d[b]}, {31'b0, e});
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int bits[9] = '{6, 7, 8, 9, 10, 11, 12, 16, 17};
    repeat (3) @(negedge clk);
    // R11 reset state
    rd(2'd0, d); chk("R11 mask", d, 0);
    rd(2'd1, d); chk("R11 raw", d, 0);
    rd(2'd2, d); chk("R11 gated", d, 0);
    chk("R11 irq", {31'b0, irq}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 register map
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R12 mask readback", d, 32'h0003_1FFF);
    rd(2'd3, d); chk("R12 clear reads 0", d, 0);
    wr(2'd0, 0);

    // R1 R2 R3 R9 pulse sources x mask
    foreach (bits[k]) begin
      for (int m = 0; m < 2; m++) begin
        logic [31:0] bv, er, eg;
        bv = 32'h1 << bits[k];
        er = (bits[k] == 6 && m == 0) ? 0 : bv;
        eg = m ? bv : 0;
        wr(2'd3, 32'hFFFF_FFFF);
        wr(2'd0, m ? bv : 0);
        pulse(bv);
        rd(2'd1, d); chk($sformatf("R1 R9 raw bit %0d m%0d", bits[k], m), d, er);
        rd(2'd2, d); chk($sformatf("R2 gated bit %0d m%0d", bits[k], m), d, eg);
        chk($sformatf("R2 irq bit %0d m%0d", bits[k], m), {31'b0, irq}, {31'b0, eg != 0});
        wr(2'd3, ~bv);
        rd(2'd1, d); chk($sformatf("R3 zeros keep bit %0d", bits[k]), d, er);
        wr(2'd3, bv);
        rd(2'd1, d); chk($sformatf("R3 ones clear bit %0d", bits[k]), d, 0);
      end
    end

    // R2 irq follows a later mask write
    wr(2'd0, 0);
    pulse(32'h100);
    chk("R2 irq masked", {31'b0, irq}, 0);
    wr(2'd0, 32'h100);
    chk("R2 irq after mask", {31'b0, irq}, 1);
    rd(2'd2, d); chk("R2 gated after mask", d, 32'h100);

    // R9 timeout seen while masked never appears
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd0, 0);
    pulse(32'h40);
    wr(2'd0, 32'h40);
    rd(2'd2, d); chk("R9 late mask gated", d, 0);
    chk("R9 late mask irq", {31'b0, irq}, 0);

    // R10 modem both edges
    for (int i = 0; i < 4; i++) begin
      wr(2'd3, 32'hFFFF_FFFF);
      @(negedge clk); modem_in[i] = 1'b1;
      @(negedge clk);
      rd(2'd1, d); chk($sformatf("R10 rise line %0d", i), d, 32'h1 << i);
      wr(2'd3, 32'hF);
      @(negedge clk);
      rd(2'd1, d); chk($sformatf("R10 stable line %0d", i), d, 0);
      @(negedge clk); modem_in[i] = 1'b0;
      @(negedge clk);
      rd(2'd1, d); chk($sformatf("R10 fall line %0d", i), d, 32'h1 << i);
    end

    // R4 event and clear in one cycle
    wr(2'd3, 32'hFFFF_FFFF);
    pulse(32'h400);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h400; pv = 32'h400;
    @(negedge clk);
    reg_wr = 1'b0; pv = '0;
    raw_bit("R4 event wins", 10, 1'b1);

    // R5 R6 transmit thresholds, FIFO on
    fifo_en = 1'b1; eot_mode = 1'b0;
    for (int t = 0; t < 15; t++) begin
      tx_trig = LW'(t);
      set_tx(LW'(15));
      wr(2'd3, 32'hFFFF_FFFF);
      set_tx(LW'(t + 1));
      raw_bit($sformatf("R5 no cross trig %0d", t), 5, 1'b0);
      set_tx(LW'(t));
      raw_bit($sformatf("R5 cross down trig %0d", t), 5, 1'b1);
      set_tx(LW'(t + 1));
      raw_bit($sformatf("R6 self clear trig %0d", t), 5, 1'b0);
    end

    // R7 receive thresholds, FIFO on
    for (int t = 1; t < 16; t++) begin
      rx_trig = LW'(t);
      set_rx(0);
      wr(2'd3, 32'hFFFF_FFFF);
      set_rx(LW'(t - 1));
      raw_bit($sformatf("R7 below trig %0d", t), 4, 1'b0);
      set_rx(LW'(t));
      raw_bit($sformatf("R7 reach trig %0d", t), 4, 1'b1);
      set_rx(LW'(t - 1));
      raw_bit($sformatf("R7 self clear trig %0d", t), 4, 1'b0);
    end

    // R6 R7 FIFO off: single-byte behaviour
    fifo_en = 1'b0; tx_trig = LW'(7); rx_trig = LW'(7);
    set_tx(1); set_rx(0);
    wr(2'd3, 32'hFFFF_FFFF);
    set_tx(0);
    raw_bit("R5 fifo off empty", 5, 1'b1);
    pulse(32'h0010_0000);
    raw_bit("R6 fifo off tx_wr clears", 5, 1'b0);
    set_rx(1);
    raw_bit("R7 fifo off byte in", 4, 1'b1);
    pulse(32'h0020_0000);
    raw_bit("R7 fifo off rx_rd clears", 4, 1'b0);

    // R8 end-of-transmission mode
    fifo_en = 1'b1; eot_mode = 1'b1; tx_trig = LW'(4);
    set_tx(8);
    wr(2'd3, 32'hFFFF_FFFF);
    set_tx(2);
    raw_bit("R8 level ignored", 5, 1'b0);
    pulse(32'h800);
    rd(2'd1, d); chk("R8 tx_done sets 5 and 11", d & 32'h820, 32'h820);
    eot_mode = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule